// File: doc/BRIEF.md
# Asynchronous Character Receiver with Parity

This block recovers characters that arrive one at a time on a single serial line that idles high. A falling edge on the line marks a possible start bit. The receiver then restarts its bit timing from that edge and checks the line again at the middle of the start bit. From there it samples the data bits, an optional parity bit and one or two stop bits, each at the middle of its bit period. The mid-bit points are counted from an oversampling enable that pulses sixteen times per bit. Because timing restarts on every character, a transmitter whose rate differs slightly from the receiver does not build up error from one character to the next.

Three runtime inputs set the frame shape: the character length (five to eight bits), the parity rule (none, even or odd) and the stop-bit count. The receiver takes a copy of these inputs only while it waits between characters. Each finished character appears as a right-aligned byte with a one-cycle strobe. A parity-mismatch flag and a stop-bit (framing) flag accompany the byte.

Top module: `async_char_rx`

## Requirements
- R1: While reset is asserted, and directly after it, `rx_valid_o`, `rx_data_o`, `par_err_o` and `frm_err_o` are all zero.
- R2: `cfg_len_i` code 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. Bits are taken least significant first and placed right-aligned in `rx_data_o`, with every bit above the character length zero.
- R3: `cfg_par_i` code 1 expects an even number of ones over the data and parity bits. Code 2 expects an odd number. Codes 0 and 3 mean that no parity bit is sent and `par_err_o` stays 0. A mismatch sets `par_err_o` for that character.
- R4: `cfg_stop_i` 0 means one stop bit and 1 means two. Each stop bit is sampled. A stop bit found low ends the character at once, with `frm_err_o` set.
- R5: Every received character produces exactly one `rx_valid_o` pulse, one clock wide. The data and both flags of that character are present in the same cycle, so a character with both a parity mismatch and a low stop bit shows both flags on its single pulse.
- R6: A low level that is gone by the middle of the start bit (8 oversample ticks after the edge) is discarded and produces no character.
- R7: After a framing error the receiver waits for the line to go high before it looks for a new start bit. A line held low for many bit times therefore yields exactly one character, with data 0 and `frm_err_o` set.
- R8: The configuration inputs are captured only between characters. A change made while a character is in flight does not affect that character.
- R9: Bit timing restarts at each start edge. Back-to-back characters with no idle gap, sent about 3 % fast or about 3 % slow, are still received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| line_i | input | 1 | Serial line, idles high, start bit low |
| cfg_len_i | input | 2 | Character length code (0..3 = 5..8 bits) |
| cfg_par_i | input | 2 | Parity rule: 0/3 none, 1 even, 2 odd |
| cfg_stop_i | input | 1 | 0 = one stop bit, 1 = two stop bits |
| rx_data_o | output | 8 | Received character, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe per character |
| par_err_o | output | 1 | Parity mismatch for the strobed character |
| frm_err_o | output | 1 | Stop bit found low for the strobed character |

## Verification
The parity check and the stop-bit check both report on the one strobe that closes a character, so they can fire in the same cycle. The bench provokes this by sending an even-parity character with an inverted parity bit and a low stop bit. The scoreboard then requires a single strobe that carries both flags along with the correct data byte. A related collision occurs when the configuration inputs change in the middle of a frame. That frame must still be decoded with the settings in force at its start edge.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int RX_DATA_W   = 8;
  localparam int RX_MIN_BITS = 5;
  localparam int RX_LEN_W    = $clog2(RX_DATA_W - RX_MIN_BITS + 1);
  localparam int RX_IDX_W    = $clog2(RX_DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_HOLD  = 3'd5
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE3 = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic [RX_LEN_W-1:0] len;
    par_mode_e           par;
    logic                two_stop;
  } rx_cfg_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  rx_cfg_t              cfg_i,
  output rx_cfg_t              cfg_q_o,
  output logic                 cap_clr_o,
  output logic                 cap_data_o,
  output logic                 cap_par_o,
  output logic [RX_IDX_W-1:0]  bit_idx_o,
  output logic                 done_o,
  output logic                 done_ferr_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] MID_T  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OSR - 1);

  rx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     tick_q, tick_d;
  logic [RX_IDX_W-1:0]  bit_q, bit_d;
  logic                 stop_q, stop_d;
  rx_cfg_t              cfg_q, cfg_d;
  logic [RX_IDX_W-1:0]  last_idx;
  logic                 hit;
  logic                 par_on;

  always_comb begin
    last_idx = RX_IDX_W'(RX_MIN_BITS - 1) + RX_IDX_W'(cfg_q.len);
    par_on   = (cfg_q.par == PAR_EVEN) || (cfg_q.par == PAR_ODD);
    hit      = tick_i && (tick_q == ((state_q == ST_START) ? MID_T : LAST_T));
  end

  always_comb begin
    state_d     = state_q;
    tick_d      = tick_q;
    bit_d       = bit_q;
    stop_d      = stop_q;
    cfg_d       = cfg_q;
    cap_clr_o   = 1'b0;
    cap_data_o  = 1'b0;
    cap_par_o   = 1'b0;
    done_o      = 1'b0;
    done_ferr_o = 1'b0;
    if (state_q != ST_IDLE && state_q != ST_HOLD && tick_i) begin
      tick_d = hit ? '0 : tick_q + CNT_W'(1);
    end
    unique case (state_q)
      ST_IDLE: begin
        cfg_d  = cfg_i;
        tick_d = '0;
        if (!line_i) state_d = ST_START;
      end
      ST_START: begin
        if (hit) begin
          if (line_i) begin
            state_d = ST_IDLE;
          end else begin
            state_d   = ST_DATA;
            bit_d     = '0;
            cap_clr_o = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (hit) begin
          cap_data_o = 1'b1;
          if (bit_q == last_idx) begin
            bit_d   = '0;
            stop_d  = 1'b0;
            state_d = par_on ? ST_PAR : ST_STOP;
          end else begin
            bit_d = bit_q + RX_IDX_W'(1);
          end
        end
      end
      ST_PAR: begin
        if (hit) begin
          cap_par_o = 1'b1;
          stop_d    = 1'b0;
          state_d   = ST_STOP;
        end
      end
      ST_STOP: begin
        if (hit) begin
          if (!line_i) begin
            done_o      = 1'b1;
            done_ferr_o = 1'b1;
            state_d     = ST_HOLD;
          end else if (cfg_q.two_stop && !stop_q) begin
            stop_d = 1'b1;
          end else begin
            done_o  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_HOLD: begin
        if (line_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      stop_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
      stop_q  <= stop_d;
      cfg_q   <= cfg_d;
    end
  end

  assign cfg_q_o   = cfg_q;
  assign bit_idx_o = bit_q;

  // R2: data bit index never passes the configured length
  assert_bit_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |-> bit_q <= last_idx);
  // R8: captured configuration frozen while a character is in flight
  assert_cfg_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |=> $stable(cfg_q));
  // R7: no new search while the line is still low after a framing error
  assert_hold_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !line_i) |=> state_q == ST_HOLD);
  // R6: a start rejected at mid-bit emits no character
  assert_glitch_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_START |-> !done_o);
endmodule

// File: rtl/rx_shift.sv
module rx_shift
  import rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 line_i,
  input  logic                 cap_clr_i,
  input  logic                 cap_data_i,
  input  logic                 cap_par_i,
  input  logic [RX_IDX_W-1:0]  bit_idx_i,
  input  par_mode_e            par_i,
  output logic [RX_DATA_W-1:0] data_o,
  output logic                 par_err_o
);
  logic [RX_DATA_W-1:0] data_q, data_d;
  logic                 odd_q, odd_d;

  always_comb begin
    data_d = data_q;
    odd_d  = odd_q;
    if (cap_clr_i) begin
      data_d = '0;
      odd_d  = 1'b0;
    end
    if (cap_data_i) begin
      data_d[bit_idx_i] = line_i;
      odd_d             = odd_q ^ line_i;
    end
    if (cap_par_i) begin
      odd_d = odd_q ^ line_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      odd_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      odd_q  <= odd_d;
    end
  end

  always_comb begin
    unique case (par_i)
      PAR_EVEN: par_err_o = odd_q;
      PAR_ODD:  par_err_o = !odd_q;
      default:  par_err_o = 1'b0;
    endcase
  end

  assign data_o = data_q;

  // R2: a fresh character starts from an all-zero word
  assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_clr_i |=> data_q == '0);
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
  import rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic [RX_LEN_W-1:0]  cfg_len_i,
  input  logic [1:0]           cfg_par_i,
  input  logic                 cfg_stop_i,
  output logic [RX_DATA_W-1:0] rx_data_o,
  output logic                 rx_valid_o,
  output logic                 par_err_o,
  output logic                 frm_err_o
);
  logic                 rst_n_i;
  logic                 line_s;
  rx_cfg_t              cfg_in, cfg_q;
  logic                 cap_clr, cap_data, cap_par, done, done_ferr;
  logic [RX_IDX_W-1:0]  bit_idx;
  logic [RX_DATA_W-1:0] word;
  logic                 perr;

  logic [RX_DATA_W-1:0] data_q, data_d;
  logic                 valid_q, valid_d, perr_q, perr_d, ferr_q, ferr_d;

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_n_i));

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk_i(clk_i), .rst_ni(rst_n_i), .d_i(line_i), .q_o(line_s));

  always_comb begin
    cfg_in.len      = cfg_len_i;
    cfg_in.par      = par_mode_e'(cfg_par_i);
    cfg_in.two_stop = cfg_stop_i;
  end

  rx_ctrl #(.OSR(OSR)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_n_i), .tick_i(tick_i), .line_i(line_s),
    .cfg_i(cfg_in), .cfg_q_o(cfg_q), .cap_clr_o(cap_clr),
    .cap_data_o(cap_data), .cap_par_o(cap_par), .bit_idx_o(bit_idx),
    .done_o(done), .done_ferr_o(done_ferr));

  rx_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_n_i), .line_i(line_s), .cap_clr_i(cap_clr),
    .cap_data_i(cap_data), .cap_par_i(cap_par), .bit_idx_i(bit_idx),
    .par_i(cfg_q.par), .data_o(word), .par_err_o(perr));

  always_comb begin
    valid_d = done;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    if (done) begin
      data_d = word;
      perr_d = perr;
      ferr_d = done_ferr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign rx_data_o  = data_q;
  assign rx_valid_o = valid_q;
  assign par_err_o  = perr_q;
  assign frm_err_o  = ferr_q;

  // R5: the strobe is never wider than one cycle
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_q |=> !valid_q);
  // R2: bits above the captured length are zero on the strobe
  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    valid_q |-> (data_q >> (RX_MIN_BITS + int'(cfg_q.len))) == '0);
  // R3: no parity flag when no parity bit is expected
  assert_no_par_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (valid_q && (cfg_q.par == PAR_NONE || cfg_q.par == PAR_NONE3)) |-> !perr_q);
endmodule

// File: tb/async_char_rx_bench.sv
module async_char_rx_bench;
  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic [1:0] tdiv = 2'd0;
  logic       line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'd0;
  logic       cfg_stop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err;

  int   checks = 0;
  int   failures = 0;
  int   bit_clk = 64;
  exp_t sb[$];

  always #5 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  async_char_rx u_async_char_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .line_i(line),
    .cfg_len_i(cfg_len), .cfg_par_i(cfg_par), .cfg_stop_i(cfg_stop),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .par_err_o(par_err), .frm_err_o(frm_err));

  task automatic put_bit(input logic v);
    line <= v;
    repeat (bit_clk) @(posedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int gap,
                           input logic bad_par, input logic bad_stop,
                           input string tag);
    int         nb;
    logic [7:0] m;
    logic       p;
    logic       pon;
    exp_t       e;
    nb  = 5 + int'(cfg_len);
    m   = d & ((8'h01 << nb) - 8'h01);
    pon = (cfg_par == 2'd1) || (cfg_par == 2'd2);
    p   = ^m;
    if (cfg_par == 2'd2) p = ~p;
    if (bad_par) p = ~p;
    e.d = m; e.pe = bad_par && pon; e.fe = bad_stop; e.tag = tag;
    sb.push_back(e);
    put_bit(1'b0);
    for (int i = 0; i < nb; i++) put_bit(d[i]);
    if (pon) put_bit(p);
    if (cfg_stop) put_bit(1'b1);
    put_bit(!bad_stop);
    for (int g = 0; g < gap; g++) put_bit(1'b1);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [1:0] p, input logic s);
    cfg_len <= l; cfg_par <= p; cfg_stop <= s;
    @(posedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      checks++;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL R5/R6 unexpected strobe data=%h pe=%b fe=%b expected none",
                 rx_data, par_err, frm_err);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rx_data !== e.d || par_err !== e.pe || frm_err !== e.fe) begin
          failures++;
          $display("FAIL %s data=%h pe=%b fe=%b expected data=%h pe=%b fe=%b",
                   e.tag, rx_data, par_err, frm_err, e.d, e.pe, e.fe);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rx_valid !== 1'b0 || rx_data !== 8'h00 || par_err !== 1'b0 || frm_err !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset v=%b d=%h pe=%b fe=%b expected all zero",
               rx_valid, rx_data, par_err, frm_err);
    end
    rst_n <= 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rx_valid !== 1'b0 || rx_data !== 8'h00 || par_err !== 1'b0 || frm_err !== 1'b0) begin
      failures++;
      $display("FAIL R1 after reset v=%b d=%h pe=%b fe=%b expected all zero",
               rx_valid, rx_data, par_err, frm_err);
    end

    // R2 lengths
    set_cfg(2'd3, 2'd0, 1'b0);
    send_char(8'hA5, 2, 1'b0, 1'b0, "R2 8 bits");
    send_char(8'hFF, 2, 1'b0, 1'b0, "R2 8 bits ones");
    set_cfg(2'd0, 2'd0, 1'b0);
    send_char(8'h0A, 2, 1'b0, 1'b0, "R2 5 bits");
    send_char(8'hF5, 2, 1'b0, 1'b0, "R2 5 bits upper zero");
    // R3 parity
    set_cfg(2'd1, 2'd1, 1'b0);
    send_char(8'h2C, 2, 1'b0, 1'b0, "R3 6 bits even");
    set_cfg(2'd2, 2'd2, 1'b0);
    send_char(8'h55, 2, 1'b0, 1'b0, "R3 7 bits odd");
    send_char(8'h55, 2, 1'b1, 1'b0, "R3 odd mismatch");
    set_cfg(2'd3, 2'd1, 1'b0);
    send_char(8'h81, 2, 1'b1, 1'b0, "R3 even mismatch");
    set_cfg(2'd3, 2'd3, 1'b0);
    send_char(8'h7E, 2, 1'b0, 1'b0, "R3 code 3 none");
    // R4 stop bits
    set_cfg(2'd3, 2'd0, 1'b1);
    send_char(8'h3C, 2, 1'b0, 1'b0, "R4 two stops");
    send_char(8'hC3, 2, 1'b0, 1'b1, "R4 second stop low");
    set_cfg(2'd3, 2'd0, 1'b0);
    send_char(8'h5A, 2, 1'b0, 1'b1, "R4 one stop low");
    // R5 both flags on one strobe
    set_cfg(2'd3, 2'd1, 1'b0);
    send_char(8'h96, 2, 1'b1, 1'b1, "R5 joint parity and framing");
    // R6 glitch: low for 4 ticks only
    set_cfg(2'd3, 2'd0, 1'b0);
    line <= 1'b0;
    repeat (16) @(posedge clk);
    line <= 1'b1;
    repeat (3 * bit_clk) @(posedge clk);
    send_char(8'h11, 2, 1'b0, 1'b0, "R6 char after glitch");
    // R7 break: line low for 20 bit times, one framing strobe
    begin
      exp_t e;
      e.d = 8'h00; e.pe = 1'b0; e.fe = 1'b1; e.tag = "R7 break";
      sb.push_back(e);
    end
    line <= 1'b0;
    repeat (20 * bit_clk) @(posedge clk);
    line <= 1'b1;
    repeat (3 * bit_clk) @(posedge clk);
    send_char(8'h42, 2, 1'b0, 1'b0, "R7 char after break");
    // R8 change config mid character
    set_cfg(2'd3, 2'd0, 1'b0);
    fork
      send_char(8'hE7, 2, 1'b0, 1'b0, "R8 config change ignored");
      begin
        repeat (2 * bit_clk) @(posedge clk);
        cfg_len <= 2'd0; cfg_par <= 2'd2; cfg_stop <= 1'b1;
      end
    join
    // R9 fast and slow transmitter, back to back
    set_cfg(2'd3, 2'd2, 1'b1);
    bit_clk = 62;
    send_char(8'h01, 0, 1'b0, 1'b0, "R9 fast 1");
    send_char(8'hFE, 0, 1'b0, 1'b0, "R9 fast 2");
    send_char(8'h6D, 2, 1'b0, 1'b0, "R9 fast 3");
    set_cfg(2'd3, 2'd0, 1'b0);
    bit_clk = 66;
    send_char(8'h80, 0, 1'b0, 1'b0, "R9 slow 1");
    send_char(8'h3B, 0, 1'b0, 1'b0, "R9 slow 2");
    send_char(8'hC4, 2, 1'b0, 1'b0, "R9 slow 3");
    bit_clk = 64;
    repeat (4 * bit_clk) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R5 strobes missing: %0d pending expected 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule